// File: doc/BRIEF.md
# Memory-mapped signed integer divider

A register-mapped divider that a host processor programs over a simple word bus. The host writes a numerator and a denominator, each split into two 32-bit words, and a 2-bit width mode. A busy flag then reads as set until the signed 64-bit quotient and remainder are ready in four read-only result words. The mode selects 32/32, 64/32 or 64/64 division. Narrow operands are sign-extended from their low word.

Any write to the control word or to an operand word starts a new division, and a new write aborts a division that is still running. The iterative core works on magnitudes and produces one quotient bit per clock, then fixes the signs. Division by zero and the single overflowing case (most negative value divided by minus one) return fixed results and raise a status flag.

Top module: `mmio_divider`

## Requirements
- R1: After reset every mapped word reads zero: control (word 0), operands (words 1 to 4) and results (words 5 to 8). Unmapped words 9 to 15 always read zero.
- R2: A write to word 0, 1, 2, 3 or 4 sets the busy bit (control bit 15). Busy reads 1 for exactly 66 clocks after the write edge. It clears on the same edge that updates the results.
- R3: In mode 0, both the numerator (lo word 1, hi word 2) and the denominator (lo word 3, hi word 4) are taken from their low words, sign-extended to 64 bits. The high words are ignored.
- R4: In modes 1 and 3, the full 64-bit numerator is divided by the denominator's low word, sign-extended.
- R5: In mode 2, the full 64-bit numerator is divided by the full 64-bit denominator.
- R6: The quotient truncates toward zero and the remainder takes the numerator's sign. The quotient is read from word 5 (low) and word 6 (high), and the remainder from word 7 (low) and word 8 (high).
- R7: If the effective denominator is zero, control bit 14 is set. The remainder equals the effective numerator. The quotient is 1 for a negative numerator and 0 otherwise.
- R8: If the effective numerator is 0x8000_0000_0000_0000 and the effective denominator is -1, bit 14 is set and the quotient equals the numerator. The remainder keeps its previous value.
- R9: A division that is neither R7 nor R8 clears bit 14.
- R10: A start write while busy aborts the running division. Busy then runs a full 66 clocks from the new write, and the results reflect only the latest operands.
- R11: A byte strobe bit k enables byte k of an operand word. A write to words 5 to 15 changes no register and does not start a division.
- R12: Control bits [1:0] hold the mode, written with strobe bit 0. Other written control bits have no effect, and bits 13:2 and 31:16 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for this cycle |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Byte enables for the write |
| rdata_o | output | 32 | Read data for addr_i, combinational |

## Verification
A fault in the iteration counter or the start logic shows directly as a busy window other than 66 clocks, within one division of the write that caused it. A corrupted partial remainder or quotient bit shows in the result words the moment busy drops. A broken sign fix-up or a wrong sign-extension shows up only in the specific signs and modes that reach it. A wrong special-case decision shows in bit 14, or as a remainder that changed when it should have held.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    MODE_W32_D32 = 2'd0,
    MODE_W64_D32 = 2'd1,
    MODE_W64_D64 = 2'd2,
    MODE_W64_D32_ALT = 2'd3
  } div_mode_e;

  localparam int A_CTRL = 0;
  localparam int A_NLO  = 1;
  localparam int A_NHI  = 2;
  localparam int A_DLO  = 3;
  localparam int A_DHI  = 4;
  localparam int A_QLO  = 5;
  localparam int A_QHI  = 6;
  localparam int A_RLO  = 7;
  localparam int A_RHI  = 8;
  localparam int NUM_OPR = 4;
  localparam int BUSY_BIT = 15;
  localparam int ZERO_BIT = 14;
endpackage

// File: rtl/div_prep.sv
module div_prep
  import div_pkg::*;
#(
  parameter int W = 64
) (
  input  div_mode_e      mode_i,
  input  logic [W-1:0]   n_raw_i,
  input  logic [W-1:0]   d_raw_i,
  output logic [W-1:0]   n_eff_o,
  output logic [W-1:0]   n_mag_o,
  output logic [W-1:0]   d_mag_o,
  output logic           neg_q_o,
  output logic           neg_r_o,
  output logic           zero_o,
  output logic           ovf_o
);
  localparam int H = W / 2;

  logic [W-1:0] n_sx, d_sx, d_eff;

  assign n_sx = {{H{n_raw_i[H-1]}}, n_raw_i[H-1:0]};
  assign d_sx = {{H{d_raw_i[H-1]}}, d_raw_i[H-1:0]};

  always_comb begin
    unique case (mode_i)
      MODE_W32_D32: begin
        n_eff_o = n_sx;
        d_eff   = d_sx;
      end
      MODE_W64_D64: begin
        n_eff_o = n_raw_i;
        d_eff   = d_raw_i;
      end
      default: begin
        n_eff_o = n_raw_i;
        d_eff   = d_sx;
      end
    endcase
  end

  assign n_mag_o = n_eff_o[W-1] ? (~n_eff_o + 1'b1) : n_eff_o;
  assign d_mag_o = d_eff[W-1] ? (~d_eff + 1'b1) : d_eff;
  assign neg_q_o = n_eff_o[W-1] ^ d_eff[W-1];
  assign neg_r_o = n_eff_o[W-1];
  assign zero_o  = (d_eff == '0);
  assign ovf_o   = (n_eff_o == {1'b1, {(W-1){1'b0}}}) && (d_eff == '1);
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] num_mag_i,
  input  logic [W-1:0] den_mag_i,
  input  logic         neg_q_i,
  input  logic         neg_r_i,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W:0]       acc_q;
  logic [W-1:0]     nq_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, neg_q_q, neg_r_q;

  logic [W:0] shifted, diff;
  logic       ge;

  assign shifted = {acc_q[W-1:0], nq_q[W-1]};
  assign diff    = shifted - {1'b0, den_q};
  assign ge      = (shifted >= {1'b0, den_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      nq_q    <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
    end else if (load_i) begin
      acc_q   <= '0;
      nq_q    <= num_mag_i;
      den_q   <= den_mag_i;
      cnt_q   <= CNT_W'(W);
      run_q   <= 1'b1;
      neg_q_q <= neg_q_i;
      neg_r_q <= neg_r_i;
    end else if (run_q) begin
      if (cnt_q != '0) begin
        acc_q <= ge ? diff : shifted;
        nq_q  <= {nq_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
      end else begin
        run_q <= 1'b0;
      end
    end
  end

  assign done_o = run_q && (cnt_q == '0);
  assign quot_o = neg_q_q ? (~nq_q + 1'b1) : nq_q;
  assign rem_o  = neg_r_q ? (~acc_q[W-1:0] + 1'b1) : acc_q[W-1:0];

  // R6
  partial_rem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && den_q != '0) |-> (acc_q < {1'b0, den_q}));

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mmio_divider.sv
module mmio_divider
  import div_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W/8-1:0] wstrb_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int STRB_W = DATA_W / 8;
  localparam int DIV_W  = 2 * DATA_W;

  div_mode_e   mode_q;
  logic        busy_q, zflag_q, start_q;
  logic [DIV_W-1:0] quot_q, rem_q;
  logic [NUM_OPR-1:0][DATA_W-1:0] opr_w;

  logic wr_start, res_we;
  logic [DIV_W-1:0] n_eff, n_mag, d_mag, core_q, core_r;
  logic neg_q, neg_r, is_zero, is_ovf, core_done;

  assign wr_start = wr_en_i && (addr_i <= ADDR_W'(A_DHI));

  for (genvar i = 0; i < NUM_OPR; i++) begin : g_opr
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= '0;
      end else if (wr_en_i && addr_i == ADDR_W'(A_NLO + i)) begin
        for (int b = 0; b < STRB_W; b++) begin
          if (wstrb_i[b]) word_q[b*8 +: 8] <= wdata_i[b*8 +: 8];
        end
      end
    end
    assign opr_w[i] = word_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_W32_D32;
    end else if (wr_en_i && addr_i == ADDR_W'(A_CTRL) && wstrb_i[0]) begin
      mode_q <= div_mode_e'(wdata_i[1:0]);
    end
  end

  div_prep #(.W(DIV_W)) i_prep (
    .mode_i  (mode_q),
    .n_raw_i ({opr_w[A_NHI-1], opr_w[A_NLO-1]}),
    .d_raw_i ({opr_w[A_DHI-1], opr_w[A_DLO-1]}),
    .n_eff_o (n_eff),
    .n_mag_o (n_mag),
    .d_mag_o (d_mag),
    .neg_q_o (neg_q),
    .neg_r_o (neg_r),
    .zero_o  (is_zero),
    .ovf_o   (is_ovf)
  );

  div_core #(.W(DIV_W)) i_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_q),
    .num_mag_i (n_mag),
    .den_mag_i (d_mag),
    .neg_q_i   (neg_q),
    .neg_r_i   (neg_r),
    .done_o    (core_done),
    .quot_o    (core_q),
    .rem_o     (core_r)
  );

  // a pending or new start supersedes a finishing run
  assign res_we = core_done && !start_q && !wr_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      zflag_q <= 1'b0;
      quot_q  <= '0;
      rem_q   <= '0;
    end else begin
      start_q <= wr_start;
      if (wr_start) busy_q <= 1'b1;
      else if (res_we) busy_q <= 1'b0;
      if (res_we) begin
        if (is_zero) begin
          zflag_q <= 1'b1;
          rem_q   <= n_eff;
          quot_q  <= {{(DIV_W-1){1'b0}}, n_eff[DIV_W-1]};
        end else if (is_ovf) begin
          zflag_q <= 1'b1;
          quot_q  <= n_eff;
        end else begin
          zflag_q <= 1'b0;
          quot_q  <= core_q;
          rem_q   <= core_r;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(A_CTRL): begin
        rdata_o[BUSY_BIT] = busy_q;
        rdata_o[ZERO_BIT] = zflag_q;
        rdata_o[1:0]      = mode_q;
      end
      ADDR_W'(A_NLO): rdata_o = opr_w[A_NLO-1];
      ADDR_W'(A_NHI): rdata_o = opr_w[A_NHI-1];
      ADDR_W'(A_DLO): rdata_o = opr_w[A_DLO-1];
      ADDR_W'(A_DHI): rdata_o = opr_w[A_DHI-1];
      ADDR_W'(A_QLO): rdata_o = quot_q[DATA_W-1:0];
      ADDR_W'(A_QHI): rdata_o = quot_q[DIV_W-1:DATA_W];
      ADDR_W'(A_RLO): rdata_o = rem_q[DATA_W-1:0];
      ADDR_W'(A_RHI): rdata_o = rem_q[DIV_W-1:DATA_W];
      default: rdata_o = '0;
    endcase
  end

  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start |=> busy_q);

  // R7
  zero_rem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_we && is_zero) |=> (rem_q == $past(n_eff) && zflag_q));

  // R8
  ovf_rem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_we && is_ovf && !is_zero) |=> ($stable(rem_q) && zflag_q));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !wr_start) |=> ($stable(quot_q) && $stable(rem_q) && !busy_q));
endmodule

// File: tb/test_mmio_divider.sv
module test_mmio_divider;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  wstrb_i = '0;
  logic [31:0] rdata_o;

  always #5 clk_i = ~clk_i;

  mmio_divider i_mmio_divider (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .wstrb_i(wstrb_i), .rdata_o(rdata_o)
  );

  typedef struct {
    logic [63:0] q;
    logic [63:0] r;
    logic        z;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] model_rem = '0;
  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(int a, logic [31:0] d, logic [3:0] s);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 4'(a); wdata_i = d; wstrb_i = s;
    @(negedge clk_i);
    wr_en_i = 1'b0; wstrb_i = '0;
  endtask

  task automatic bus_rd(int a, output logic [31:0] d);
    addr_i = 4'(a);
    #1;
    d = rdata_o;
  endtask

  task automatic wait_done(string tag);
    logic [31:0] v;
    int cnt = 0;
    forever begin
      bus_rd(0, v);
      if (!v[15] || cnt > 1000) break;
      cnt++;
      @(negedge clk_i);
    end
    chk({tag, " busy length"}, 64'(cnt), 64'd66);
  endtask

  function automatic logic [63:0] sx(logic [63:0] x);
    return {{32{x[31]}}, x[31:0]};
  endfunction

  task automatic push_exp(logic [1:0] m, logic [63:0] n, logic [63:0] d, string tag);
    exp_t e;
    logic [63:0] ne, de;
    ne = (m == 2'd0) ? sx(n) : n;
    de = (m == 2'd2) ? d : sx(d);
    e.tag = tag;
    if (de == 64'd0) begin
      e.z = 1'b1; e.r = ne; e.q = ne[63] ? 64'd1 : 64'd0;
    end else if (ne == MIN64 && de == '1) begin
      e.z = 1'b1; e.q = ne; e.r = model_rem;
    end else begin
      e.z = 1'b0;
      e.q = 64'($signed(ne) / $signed(de));
      e.r = 64'($signed(ne) % $signed(de));
    end
    model_rem = e.r;
    sb.push_back(e);
  endtask

  task automatic pop_cmp();
    exp_t e;
    logic [31:0] lo, hi, c;
    e = sb.pop_front();
    bus_rd(5, lo); bus_rd(6, hi);
    chk({e.tag, " quotient"}, {hi, lo}, e.q);
    bus_rd(7, lo); bus_rd(8, hi);
    chk({e.tag, " remainder"}, {hi, lo}, e.r);
    bus_rd(0, c);
    chk({e.tag, " flag bit14"}, 64'(c[14]), 64'(e.z));
  endtask

  task automatic run_op(logic [1:0] m, logic [63:0] n, logic [63:0] d, string tag);
    bus_wr(0, 32'(m), 4'hF);
    bus_wr(1, n[31:0], 4'hF);
    bus_wr(2, n[63:32], 4'hF);
    bus_wr(3, d[31:0], 4'hF);
    bus_wr(4, d[63:32], 4'hF);
    push_exp(m, n, d, tag);
    wait_done(tag);
    pop_cmp();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, qlo;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int a = 0; a < 9; a++) begin
      bus_rd(a, v);
      chk($sformatf("R1 reset word %0d", a), 64'(v), 64'd0);
    end
    bus_rd(12, v);
    chk("R1 unmapped word reads zero", 64'(v), 64'd0);

    // R3 mode 0, high words ignored
    run_op(2'd0, 64'd100, 64'd7, "R3 pos/pos");
    run_op(2'd0, 64'hDEAD_BEEF_FFFF_FF9C, 64'h1234_0000_0000_0007, "R3 neg/pos hi ignored");
    run_op(2'd0, 64'd100, 64'h0000_0000_FFFF_FFF9, "R6 pos/neg");
    run_op(2'd0, 64'hFFFF_FF9C, 64'hFFFF_FFF9, "R6 neg/neg");
    run_op(2'd0, 64'h8000_0000, 64'hFFFF_FFFF, "R9 mode0 min32 by -1");
    // R4 modes 1 and 3
    run_op(2'd1, 64'h0123_4567_89AB_CDEF, 64'h5555_0000_FFFF_FFF9, "R4 mode1");
    run_op(2'd3, 64'hF123_4567_89AB_CDEF, 64'h0000_0001_0000_1000, "R4 mode3");
    // R5 mode 2
    run_op(2'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0003, "R5 mode2");
    run_op(2'd2, 64'h8000_0000_0000_0001, 64'hFFFF_FFFE_0000_0000, "R5 mode2 neg");
    // R7 divide by zero
    run_op(2'd0, 64'hFFFF_FFF0, 64'h0000_0005_0000_0000, "R7 mode0 zero neg num");
    run_op(2'd2, 64'h0000_0042_0000_0001, 64'd0, "R7 mode2 zero pos num");
    run_op(2'd1, 64'd9, 64'd4, "R9 clears after zero");
    // R8 overflow
    run_op(2'd2, MIN64, '1, "R8 mode2 overflow");
    run_op(2'd1, MIN64, 64'h0000_0000_FFFF_FFFF, "R8 mode1 overflow");
    run_op(2'd2, 64'd77, 64'd10, "R9 clears after overflow");

    // R10 abort by a new write while busy
    bus_wr(0, 32'd2, 4'hF);
    bus_wr(1, 32'd1000, 4'hF);
    bus_wr(2, 32'd0, 4'hF);
    bus_wr(3, 32'd3, 4'hF);
    bus_wr(4, 32'd0, 4'hF);
    repeat (10) @(negedge clk_i);
    bus_wr(3, 32'd7, 4'hF);
    push_exp(2'd2, 64'd1000, 64'd7, "R10 abort");
    wait_done("R10 abort");
    pop_cmp();

    // R11 byte strobes
    bus_wr(1, 32'hAABB_CCDD, 4'hF);
    bus_wr(1, 32'h1122_3344, 4'b0101);
    bus_rd(1, v);
    chk("R11 byte strobe merge", 64'(v), 64'hAA22_CC44);
    push_exp(2'd2, 64'hAA22_CC44, 64'd7, "R11 strobed operand");
    wait_done("R11 strobed operand");
    pop_cmp();
    bus_rd(5, qlo);
    bus_wr(5, 32'h0BAD_F00D, 4'hF);
    bus_rd(0, v);
    chk("R11 result write no start", 64'(v[15]), 64'd0);
    bus_rd(5, v);
    chk("R11 result write ignored", 64'(v), 64'(qlo));
    bus_wr(10, 32'hFFFF_FFFF, 4'hF);
    bus_rd(0, v);
    chk("R11 unmapped write no start", 64'(v[15]), 64'd0);

    // R12 control field isolation
    bus_wr(0, 32'hFFFF_FFFF, 4'hF);
    bus_rd(0, v);
    chk("R12 mode readback", 64'(v[1:0]), 64'd3);
    chk("R12 reserved bits", 64'({v[31:16], v[13:2]}), 64'd0);
    push_exp(2'd3, 64'hAA22_CC44, 64'd7, "R12 mode3 result");
    wait_done("R12 mode3 result");
    pop_cmp();
    bus_wr(0, 32'h0000_0002, 4'b1110);
    bus_rd(0, v);
    chk("R12 strobe0 gates mode", 64'(v[1:0]), 64'd3);
    push_exp(2'd3, 64'hAA22_CC44, 64'd7, "R12 gated write");
    wait_done("R12 gated write");
    pop_cmp();

    // random operands, every mode
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 8; k++) begin
        logic [63:0] n, d;
        n = {$urandom(), $urandom()};
        d = (k < 3) ? 64'($signed(32'($urandom() % 97) - 48)) : {$urandom(), $urandom()};
        if (k == 7) d = 64'd0;
        run_op(2'(m), n, d, $sformatf("R6 random mode%0d #%0d", m, k));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule